// File: doc/BRIEF.md
# Shared-Interval Sixteen-Channel Input Debouncer

This block cleans up sixteen asynchronous digital inputs before software or downstream logic sees them. Every input first crosses into the clock domain through a two-stage synchroniser. Each channel then runs a small state machine of its own. A new level is copied into the debounced register only after it has been sampled without interruption for a programmable number of clock cycles. All sixteen channels use that single interval.

A debounce-enable bit and an interval value configure the block. Both are captured into internal registers that reset to "off" and zero. When filtering is off, or the interval is zero, a synchronised change goes straight into the register. Whenever a register bit changes, the channel gives a one-cycle pulse on its rising or falling output, so a later interrupt stage can pick the edge directions it cares about.

Each channel machine has two states:
- `CH_IDLE`: the register bit agrees with the synchronised input.
- `CH_QUAL`: a differing level is being timed.

It has four transitions:
- *arm* (`CH_IDLE` to `CH_QUAL`): the input differs and filtering is active; the counter loads 1.
- *bypass-accept* (`CH_IDLE` to `CH_IDLE`): the input differs and filtering is inactive; the bit is taken at once.
- *abandon* (`CH_QUAL` to `CH_IDLE`): the input has returned to the registered level; nothing is updated.
- *accept* (`CH_QUAL` to `CH_IDLE`): the counter has reached the interval; the bit is updated.

Top module: `deb_filter16`

## Requirements
- R1: After reset, `dout`, `rise_pulse` and `fall_pulse` are all zero, debouncing is disabled and the interval is 0.
- R2: With `deb_en` = 0, or with `deb_time` = 0, a `din` change that stays stable appears on `dout` on the third rising clock edge after it is applied.
- R3: With `deb_en` = 1 and `deb_time` = T (T ≥ 1), a `din` change held steadily appears on `dout` on rising edge 3+T after it is applied, and not earlier.
- R4: With debouncing active, a `din` level that lasts P clock cycles before returning is accepted if P ≥ T+1 and ignored (the `dout` bit keeps its value) if P ≤ T. A return to the registered level restarts that channel's count.
- R5: Channels qualify independently: bits that change together, with bits that stay, each follow R2 to R4 on their own.
- R6: Bit i of `rise_pulse` is 1 for exactly the one cycle in which `dout[i]` has just changed from 0 to 1. Bit i of `fall_pulse` is 1 for exactly the one cycle in which `dout[i]` has just changed from 1 to 0. The two are never 1 together for the same bit.
- R7: `deb_en` and `deb_time` are registered inside the block. The sixteen channels all use the one registered interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Raw asynchronous inputs |
| deb_en | input | 1 | 1 enables filtering |
| deb_time | input | 16 | Shared stability interval in clock cycles |
| dout | output | 16 | Debounced input register |
| rise_pulse | output | 16 | One-cycle pulse per bit on an accepted 0-to-1 update |
| fall_pulse | output | 16 | One-cycle pulse per bit on an accepted 1-to-0 update |

## Verification
The synchroniser takes two edges, so a change that is not filtered reaches `dout` and the pulse outputs on the third edge after it is driven. With an interval T the change lands on edge 3+T. Inputs are driven on the falling edge, and each vector waits an exact number of rising edges before sampling on the next falling edge. For every latency the bench therefore checks the edge just before the change (old value) and the edge of the change (new value). Glitch vectors hold a level for T and T+1 cycles, which pins the accept threshold to one cycle.

// File: rtl/deb_pkg.sv
package deb_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_QUAL = 1'b1
    } ch_state_t;
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/deb_chan.sv
module deb_chan
    import deb_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_i,
    input  logic              bypass_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              q_o,
    output logic              rise_o,
    output logic              fall_o
);
    ch_state_t         st_q, st_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic              q_q, q_d;
    logic              rise_q, fall_q;
    logic              accept;

    // next-state and update decision
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        accept = 1'b0;
        unique case (st_q)
            CH_IDLE: begin
                if (s_i != q_q) begin
                    if (bypass_i) begin
                        accept = 1'b1;            // bypass-accept
                    end else begin
                        st_d  = CH_QUAL;          // arm
                        cnt_d = TIME_W'(1);
                    end
                end
            end
            CH_QUAL: begin
                if (s_i == q_q) begin
                    st_d = CH_IDLE;               // abandon
                end else if (bypass_i || cnt_q >= time_i) begin
                    accept = 1'b1;                // accept
                    st_d   = CH_IDLE;
                end else begin
                    cnt_d = cnt_q + TIME_W'(1);
                end
            end
            default: st_d = CH_IDLE;
        endcase
        q_d = accept ? s_i : q_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            q_q    <= q_d;
            rise_q <= accept & s_i;
            fall_q <= accept & ~s_i;
        end
    end

    assign q_o    = q_q;
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R6
    rise_marks_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (q_q && !$past(q_q)));
    // R6
    fall_marks_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!q_q && $past(q_q)));
    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q));
    // R3
    filtered_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_q != $past(q_q)) && !$past(bypass_i)) |->
            ($past(st_q) == CH_QUAL && $past(cnt_q) >= $past(time_i)));
endmodule

// File: rtl/deb_filter16.sv
module deb_filter16
    import deb_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   din,
    input  logic              deb_en,
    input  logic [TIME_W-1:0] deb_time,
    output logic [N_CH-1:0]   dout,
    output logic [N_CH-1:0]   rise_pulse,
    output logic [N_CH-1:0]   fall_pulse
);
    logic              en_q;
    logic [TIME_W-1:0] time_q;
    logic              bypass;
    logic [N_CH-1:0]   din_s;

    // R7 configuration registers, cleared by reset (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            time_q <= '0;
        end else begin
            en_q   <= deb_en;
            time_q <= deb_time;
        end
    end

    assign bypass = !en_q || (time_q == '0);

    deb_sync #(.WIDTH(N_CH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (din),
        .sync_o  (din_s)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        deb_chan #(.TIME_W(TIME_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .s_i      (din_s[i]),
            .bypass_i (bypass),
            .time_i   (time_q),
            .q_o      (dout[i]),
            .rise_o   (rise_pulse[i]),
            .fall_o   (fall_pulse[i])
        );
    end

    // R6
    pulse_tracks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_pulse | fall_pulse) == (dout ^ $past(dout))));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (dout == '0 && rise_pulse == '0 && fall_pulse == '0));
endmodule

// File: tb/tb_deb_filter16.sv
module tb_deb_filter16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic        deb_en = 1'b0;
    logic [15:0] deb_time = '0;
    logic [15:0] dout, rise_pulse, fall_pulse;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    deb_filter16 dut (
        .clk(clk), .rst_n(rst_n), .din(din), .deb_en(deb_en),
        .deb_time(deb_time), .dout(dout), .rise_pulse(rise_pulse),
        .fall_pulse(fall_pulse)
    );

    // {en, time, din, edges to wait, expected dout}
    localparam int NV = 18;
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 16'd0, 16'hA5A5, 8'd3,  16'hA5A5},  // R2
        {1'b0, 16'd0, 16'hFFFF, 8'd2,  16'hA5A5},  // R2 not yet
        {1'b0, 16'd0, 16'hFFFF, 8'd1,  16'hFFFF},  // R2
        {1'b1, 16'd4, 16'h0000, 8'd6,  16'hFFFF},  // R3 not yet
        {1'b1, 16'd4, 16'h0000, 8'd1,  16'h0000},  // R3
        {1'b1, 16'd0, 16'h00FF, 8'd3,  16'h00FF},  // R2 time 0
        {1'b1, 16'd4, 16'hFF00, 8'd3,  16'h00FF},  // R4 glitch
        {1'b1, 16'd4, 16'h00FF, 8'd10, 16'h00FF},  // R4 ignored
        {1'b1, 16'd4, 16'hFF00, 8'd7,  16'hFF00},  // R5 mixed
        {1'b1, 16'd4, 16'h00FF, 8'd6,  16'hFF00},  // R5
        {1'b1, 16'd4, 16'h00FF, 8'd1,  16'h00FF},  // R5
        {1'b1, 16'd4, 16'hFF00, 8'd5,  16'h00FF},  // R4 P=T+1
        {1'b1, 16'd4, 16'h00FF, 8'd2,  16'hFF00},  // R4 accepted
        {1'b1, 16'd4, 16'h00FF, 8'd10, 16'h00FF},  // R4
        {1'b1, 16'd4, 16'hF0F0, 8'd4,  16'h00FF},  // R4 P=T
        {1'b1, 16'd4, 16'h00FF, 8'd10, 16'h00FF},  // R4 rejected
        {1'b1, 16'd1, 16'h0F0F, 8'd3,  16'h00FF},  // R3 T=1 not yet
        {1'b1, 16'd1, 16'h0F0F, 8'd1,  16'h0F0F}   // R3 T=1
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        deb_en   = 1'b1;
        deb_time = 16'd4;
        din      = 16'hFFFF;
        edges(3);
        check("R1 dout in reset", dout, 16'h0000);
        check("R1 rise in reset", rise_pulse, 16'h0000);
        check("R1 fall in reset", fall_pulse, 16'h0000);
        din = '0;
        edges(4);
        rst_n = 1'b1;
        edges(4);
        check("R1 dout after reset", dout, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            deb_en   = VEC[i][56];
            deb_time = VEC[i][55:40];
            din      = VEC[i][39:24];
            edges(int'(VEC[i][23:16]));
            check($sformatf("R2-R5 vector %0d", i), dout, VEC[i][15:0]);
        end

        // R6 pulses on a bypass update, dout = 0F0F here
        deb_en = 1'b0;
        din    = 16'hF0F0;
        edges(2);
        check("R6 rise before", rise_pulse, 16'h0000);
        edges(1);
        check("R6 rise", rise_pulse, 16'hF0F0);
        check("R6 fall", fall_pulse, 16'h0F0F);
        check("R6 dout", dout, 16'hF0F0);
        edges(1);
        check("R6 rise one cycle", rise_pulse, 16'h0000);
        check("R6 fall one cycle", fall_pulse, 16'h0000);

        // R7 single shared interval: T=2 applies to every bit
        deb_en   = 1'b1;
        deb_time = 16'd2;
        din      = 16'h0FF0;
        edges(4);
        check("R7 shared not yet", dout, 16'hF0F0);
        edges(1);
        check("R7 shared", dout, 16'h0FF0);

        // R1 reset mid-run clears register
        rst_n = 1'b0;
        edges(1);
        check("R1 mid-run reset", dout, 16'h0000);
        rst_n = 1'b1;
        din   = 16'h0000;
        edges(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule